// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Allocator

This block decides, once per clock, how many queued macro-instructions a group of unequal parallel decoders takes. Instructions enter an in-order queue, each tagged with the number of micro-ops it expands to. The first slot is the wide one and takes any instruction of one to four micro-ops. The two narrow slots behind it take only single-micro-op instructions. Allocation always takes a prefix of the queue in program order. At the first instruction that does not fit the next slot, that slot and all slots after it stay empty, and the instruction waits for the wide slot in a later cycle.

Each cycle the chosen entries are popped. A registered result appears one clock later. It gives a valid flag and a micro-op count for each slot, the number popped, and the micro-op total. Two flags mark an over-long instruction and an illegal zero count. A running counter records how many cycles produced any decode. A stall input freezes allocation.

Top module: `decode_slot_alloc`

## Requirements
- R1: While rst_ni is low, and until the first allocation after it, every output is zero and full_o is low.
- R2: When the queue holds entries and stall_i is low, slot 0 takes the head entry. Its count, in the range 1 to 4, appears on slot_uops_o[2:0] one cycle later with slot_vld_o[0] high.
- R3: Slot k (k = 1, 2; field slot_uops_o[3k+2:3k]) takes queue entry k only when slot k-1 took an entry, entry k exists, and its count is 0 or 1. It then reports a count of 1. Otherwise slot k and every later slot stay invalid.
- R4: A head entry with a count above 4 is taken by slot 0 alone and reported with its real count. long_o is high and slots 1 and 2 are invalid in that cycle.
- R5: A taken entry with a count of 0 is reported as 1 micro-op, and err_o is high in that output cycle.
- R6: When stall_i is high, or the queue is empty, nothing is popped. All slot valids, pop_cnt_o, total_uops_o, long_o and err_o are zero one cycle later.
- R7: slot_vld_o is always a prefix of ones (000, 001, 011, 111). pop_cnt_o equals the number of valid slots, and total_uops_o equals the sum of the valid slots' counts.
- R8: cyc_cnt_o increases by one in every output cycle with at least one valid slot, and holds otherwise.
- R9: A queue holding counts 2,2,2,2,2,1,1,1 with no stall drains in exactly 6 allocation cycles. The pop counts are 1,1,1,1,3,1.
- R10: A push is accepted while the queue holds fewer than 8 entries (counted before that cycle's pops). full_o is high exactly when it holds 8, and a push while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Enqueue one instruction |
| push_uops_i | input | 3 | Micro-op count of the pushed instruction |
| stall_i | input | 1 | Freeze allocation this cycle |
| full_o | output | 1 | Queue holds DEPTH entries |
| slot_vld_o | output | 3 | Per-slot valid, bit k for slot k |
| slot_uops_o | output | 9 | Per-slot micro-op count, 3 bits per slot, slot 0 lowest |
| pop_cnt_o | output | 2 | Entries taken in the allocation cycle |
| total_uops_o | output | 4 | Sum of the valid slots' counts |
| long_o | output | 1 | Slot 0 holds an instruction longer than 4 micro-ops |
| err_o | output | 1 | A taken entry had an illegal count of 0 |
| cyc_cnt_o | output | 16 | Cycles with at least one valid slot |

## Verification
A corrupted read pointer or level shows up within one output cycle. The valid pattern or reported counts then part from the bench's in-order queue model, or full_o changes at the wrong fill level. A wrong fit test in the allocator shows at once as a valid pattern that runs past a multi-micro-op entry. It can also show as a wrong pop count, which shifts every later group in the stream. A slipped counter diverges on the first busy cycle and never recovers.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  localparam int unsigned UOP_W = 3;
  typedef logic [UOP_W-1:0] uop_t;
endpackage

// File: rtl/dsa_queue.sv
module dsa_queue
  import dsa_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NSLOT = 3,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned PW = $clog2(NSLOT + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  uop_t                   push_uop_i,
  input  logic [PW-1:0]          pop_n_i,
  output uop_t [NSLOT-1:0]       peek_o,
  output logic [LW-1:0]          level_o,
  output logic                   full_o
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  uop_t          mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] level;
  logic          push_ok;

  function automatic logic [AW-1:0] adv(logic [AW-1:0] p, int unsigned k);
    int unsigned s;
    s = int'(p) + k;
    while (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  assign push_ok = push_i && (level < DEPTH_L);

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= push_uop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      rd_ptr <= adv(rd_ptr, int'(pop_n_i));
      if (push_ok) wr_ptr <= adv(wr_ptr, 1);
      level <= level + LW'(push_ok) - LW'(pop_n_i);
    end
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_peek
    assign peek_o[k] = mem[adv(rd_ptr, k)];
  end

  assign level_o = level;
  assign full_o  = (level == DEPTH_L);
endmodule

// File: rtl/dsa_pick.sv
module dsa_pick
  import dsa_pkg::*;
#(
  parameter int unsigned NSLOT     = 3,
  parameter int unsigned SLOT0_MAX = 4,
  parameter int unsigned LW        = 4,
  localparam int unsigned PW       = $clog2(NSLOT + 1),
  localparam int unsigned TOT_W    = $clog2((1 << UOP_W) + NSLOT)
) (
  input  uop_t [NSLOT-1:0] peek_i,
  input  logic [LW-1:0]    level_i,
  input  logic             stall_i,
  output logic [NSLOT-1:0] vld_o,
  output uop_t [NSLOT-1:0] uops_o,
  output logic [PW-1:0]    pop_n_o,
  output logic [TOT_W-1:0] tot_o,
  output logic             long_o,
  output logic             err_o
);
  logic open;

  always_comb begin
    vld_o  = '0;
    uops_o = '0;
    long_o = 1'b0;
    err_o  = 1'b0;
    open   = 1'b0;
    if (!stall_i && level_i != '0) begin
      vld_o[0]  = 1'b1;
      uops_o[0] = (peek_i[0] == '0) ? uop_t'(1) : peek_i[0];
      long_o    = int'(peek_i[0]) > SLOT0_MAX;
      err_o     = (peek_i[0] == '0);
      open      = !long_o;
      // narrow slots: single-op only, stop at first misfit
      for (int k = 1; k < NSLOT; k++) begin
        if (open && int'(level_i) > k && peek_i[k] <= uop_t'(1)) begin
          vld_o[k]  = 1'b1;
          uops_o[k] = uop_t'(1);
          err_o     = err_o | (peek_i[k] == '0);
        end else begin
          open = 1'b0;
        end
      end
    end
  end

  always_comb begin
    pop_n_o = '0;
    tot_o   = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (vld_o[k]) begin
        pop_n_o = pop_n_o + PW'(1);
        tot_o   = tot_o + TOT_W'(uops_o[k]);
      end
    end
  end
endmodule

// File: rtl/dsa_outreg.sv
module dsa_outreg
  import dsa_pkg::*;
#(
  parameter int unsigned NSLOT = 3,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PW   = $clog2(NSLOT + 1),
  localparam int unsigned TOT_W = $clog2((1 << UOP_W) + NSLOT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSLOT-1:0] vld_i,
  input  uop_t [NSLOT-1:0] uops_i,
  input  logic [PW-1:0]    pop_n_i,
  input  logic [TOT_W-1:0] tot_i,
  input  logic             long_i,
  input  logic             err_i,
  output logic [NSLOT-1:0] vld_o,
  output uop_t [NSLOT-1:0] uops_o,
  output logic [PW-1:0]    pop_n_o,
  output logic [TOT_W-1:0] tot_o,
  output logic             long_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= '0;
      uops_o  <= '0;
      pop_n_o <= '0;
      tot_o   <= '0;
      long_o  <= 1'b0;
      err_o   <= 1'b0;
      cnt_o   <= '0;
    end else begin
      vld_o   <= vld_i;
      uops_o  <= uops_i;
      pop_n_o <= pop_n_i;
      tot_o   <= tot_i;
      long_o  <= long_i;
      err_o   <= err_i;
      if (vld_i != '0) cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/decode_slot_alloc.sv
module decode_slot_alloc
  import dsa_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned NSLOT     = 3,
  parameter int unsigned SLOT0_MAX = 4,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned PW    = $clog2(NSLOT + 1),
  localparam int unsigned LW    = $clog2(DEPTH + 1),
  localparam int unsigned TOT_W = $clog2((1 << UOP_W) + NSLOT)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [UOP_W-1:0]       push_uops_i,
  input  logic                   stall_i,
  output logic                   full_o,
  output logic [NSLOT-1:0]       slot_vld_o,
  output logic [NSLOT*UOP_W-1:0] slot_uops_o,
  output logic [PW-1:0]          pop_cnt_o,
  output logic [TOT_W-1:0]       total_uops_o,
  output logic                   long_o,
  output logic                   err_o,
  output logic [CNT_W-1:0]       cyc_cnt_o
);
  uop_t [NSLOT-1:0] peek, pick_uops, q_uops;
  logic [LW-1:0]    level;
  logic [NSLOT-1:0] pick_vld;
  logic [PW-1:0]    pick_n;
  logic [TOT_W-1:0] pick_tot;
  logic             pick_long, pick_err;

  dsa_queue #(.DEPTH(DEPTH), .NSLOT(NSLOT)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .push_uop_i (push_uops_i),
    .pop_n_i    (pick_n),
    .peek_o     (peek),
    .level_o    (level),
    .full_o     (full_o)
  );

  dsa_pick #(.NSLOT(NSLOT), .SLOT0_MAX(SLOT0_MAX), .LW(LW)) u_pick (
    .peek_i  (peek),
    .level_i (level),
    .stall_i (stall_i),
    .vld_o   (pick_vld),
    .uops_o  (pick_uops),
    .pop_n_o (pick_n),
    .tot_o   (pick_tot),
    .long_o  (pick_long),
    .err_o   (pick_err)
  );

  dsa_outreg #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (pick_vld),
    .uops_i  (pick_uops),
    .pop_n_i (pick_n),
    .tot_i   (pick_tot),
    .long_i  (pick_long),
    .err_i   (pick_err),
    .vld_o   (slot_vld_o),
    .uops_o  (q_uops),
    .pop_n_o (pop_cnt_o),
    .tot_o   (total_uops_o),
    .long_o  (long_o),
    .err_o   (err_o),
    .cnt_o   (cyc_cnt_o)
  );

  assign slot_uops_o = q_uops;
endmodule

// File: rtl/dsa_chk.sv
module dsa_chk #(
  parameter int unsigned NSLOT     = 3,
  parameter int unsigned UW        = 3,
  parameter int unsigned SLOT0_MAX = 4,
  parameter int unsigned PW        = 2,
  parameter int unsigned TOT_W     = 4,
  parameter int unsigned CNT_W     = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                stall_i,
  input logic [NSLOT-1:0]    slot_vld_o,
  input logic [NSLOT*UW-1:0] slot_uops_o,
  input logic [PW-1:0]       pop_cnt_o,
  input logic [TOT_W-1:0]    total_uops_o,
  input logic                long_o,
  input logic                err_o,
  input logic [CNT_W-1:0]    cyc_cnt_o
);
  // R6
  stall_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (slot_vld_o == '0 && pop_cnt_o == '0 && total_uops_o == '0));

  // R7
  vld_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((slot_vld_o + NSLOT'(1)) & slot_vld_o) == '0);

  // R7
  pop_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_cnt_o) == $countones(slot_vld_o));

  // R4
  long_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_o |-> (slot_vld_o == NSLOT'(1) && int'(slot_uops_o[UW-1:0]) > SLOT0_MAX));

  // R2
  wide_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o[0] && !long_o) |-> (slot_uops_o[UW-1:0] != '0 &&
                                    int'(slot_uops_o[UW-1:0]) <= SLOT0_MAX));

  // R5
  err_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> slot_vld_o[0]);

  // R8
  busy_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o != '0) |-> cyc_cnt_o == $past(cyc_cnt_o) + CNT_W'(1));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_o == '0) |-> $stable(cyc_cnt_o));

  for (genvar k = 1; k < NSLOT; k++) begin : g_narrow
    // R3
    narrow_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[k] |-> slot_uops_o[k*UW +: UW] == UW'(1));
  end
endmodule

bind decode_slot_alloc dsa_chk #(
  .NSLOT(NSLOT), .UW(dsa_pkg::UOP_W), .SLOT0_MAX(SLOT0_MAX),
  .PW(PW), .TOT_W(TOT_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .slot_vld_o   (slot_vld_o),
  .slot_uops_o  (slot_uops_o),
  .pop_cnt_o    (pop_cnt_o),
  .total_uops_o (total_uops_o),
  .long_o       (long_o),
  .err_o        (err_o),
  .cyc_cnt_o    (cyc_cnt_o)
);

// File: tb/sim_decode_slot_alloc.sv
module sim_decode_slot_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic push_i = 1'b0;
  logic [2:0] push_uops_i = '0;
  logic stall_i = 1'b1;
  logic full_o;
  logic [2:0] slot_vld_o;
  logic [8:0] slot_uops_o;
  logic [1:0] pop_cnt_o;
  logic [3:0] total_uops_o;
  logic long_o, err_o;
  logic [15:0] cyc_cnt_o;

  int checks = 0;
  int errors = 0;
  int mq[$];
  int mcnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  decode_slot_alloc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_uops_i(push_uops_i),
    .stall_i(stall_i), .full_o(full_o), .slot_vld_o(slot_vld_o),
    .slot_uops_o(slot_uops_o), .pop_cnt_o(pop_cnt_o), .total_uops_o(total_uops_o),
    .long_o(long_o), .err_o(err_o), .cyc_cnt_o(cyc_cnt_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive, model, compare after edge
  task automatic step(bit p, int v, bit st, output int took);
    int n, ev, etot, ecur, eu[3];
    bit el, ee, open;
    n = mq.size();
    ev = 0; etot = 0; el = 0; ee = 0;
    eu[0] = 0; eu[1] = 0; eu[2] = 0;
    if (!st && n > 0) begin
      ev = 1;
      eu[0] = (mq[0] == 0) ? 1 : mq[0];
      el = mq[0] > 4;
      ee = mq[0] == 0;
      open = !el;
      for (int k = 1; k < 3; k++) begin
        if (open && n > k && mq[k] <= 1) begin
          ev |= (1 << k); eu[k] = 1; ee |= (mq[k] == 0);
        end else open = 0;
      end
    end
    took = $countones(ev);
    for (int k = 0; k < 3; k++) etot += eu[k];
    for (int k = 0; k < took; k++) void'(mq.pop_front());
    if (p && n < DEPTH) mq.push_back(v);
    if (took > 0) mcnt = (mcnt + 1) & 16'hffff;
    push_i = p; push_uops_i = 3'(v); stall_i = st;
    @(posedge clk_i); #1;
    push_i = 0;
    ecur = int'(slot_vld_o);
    check(ecur == ev, (st || n == 0) ? "R6" : "R3", ecur, ev);
    for (int k = 0; k < 3; k++)
      check(int'(slot_uops_o[k*3 +: 3]) == eu[k], k == 0 ? "R2" : "R3",
            int'(slot_uops_o[k*3 +: 3]), eu[k]);
    check(int'(pop_cnt_o) == took, "R7", int'(pop_cnt_o), took);
    check(int'(total_uops_o) == etot, "R7", int'(total_uops_o), etot);
    check(long_o == el, "R4", int'(long_o), int'(el));
    check(err_o == ee, "R5", int'(err_o), int'(ee));
    check(int'(cyc_cnt_o) == mcnt, "R8", int'(cyc_cnt_o), mcnt);
    check(full_o == (mq.size() == DEPTH), "R10", int'(full_o), int'(mq.size() == DEPTH));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t, lfsr, cyc;
    int pops[6];
    int exp_pops[6] = '{1, 1, 1, 1, 3, 1};
    int seq[8] = '{2, 2, 2, 2, 2, 1, 1, 1};
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    check(slot_vld_o == 0 && pop_cnt_o == 0 && total_uops_o == 0, "R1", int'(slot_vld_o), 0);
    check(!long_o && !err_o && !full_o && cyc_cnt_o == 0, "R1", int'(cyc_cnt_o), 0);
    rst_ni = 1'b1;
    step(0, 0, 0, t);
    check(t == 0 && cyc_cnt_o == 0, "R1", int'(cyc_cnt_o), 0);

    // exhaustive three-entry windows
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          step(1, a, 1, t);
          step(1, b, 1, t);
          step(1, c, 1, t);
          while (mq.size() > 0) step(0, 0, 0, t);
          step(0, 0, 0, t);
        end

    // R10 overfill and drain
    for (int k = 0; k < 10; k++) step(1, k % 2, 1, t);
    check(full_o == 1'b1, "R10", int'(full_o), 1);
    step(1, 1, 0, t);
    while (mq.size() > 0) step(0, 0, 0, t);
    check(full_o == 1'b0, "R10", int'(full_o), 0);

    // R9 reference stream
    for (int k = 0; k < 8; k++) step(1, seq[k], 1, t);
    cyc = 0;
    while (mq.size() > 0 && cyc < 6) begin
      step(0, 0, 0, t);
      pops[cyc] = t;
      cyc++;
    end
    check(mq.size() == 0 && cyc == 6, "R9", cyc, 6);
    for (int k = 0; k < 6; k++) check(pops[k] == exp_pops[k], "R9", pops[k], exp_pops[k]);

    // mixed pushes, stalls and allocation
    lfsr = 32'h1234;
    for (int k = 0; k < 2000; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      step(lfsr[0] | lfsr[5], (lfsr >> 2) & 7, (lfsr & 32'h0300) == 32'h0300, t);
    end
    while (mq.size() > 0) step(0, 0, 0, t);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule